// File: doc/BRIEF.md
# Unsigned Integer Divide Execution Unit

This unit executes one unsigned divide instruction at a time. The caller presents a 32-bit instruction word, a flag that selects which of two 32-bit encodings the word uses, the current N/Z/C/V flags and a start strobe. The unit decodes the destination, dividend and divisor register indices from the word. It places the two source indices on a register-read port and captures the returned values when it accepts the start. It then evaluates the condition code and divides.

The quotient comes from a restoring shift-subtract loop that retires one bit per clock. A zero divisor skips the loop and yields zero, with no trap. A word that does not match either bit pattern raises a one-cycle `undef` pulse instead of a result. Results leave on a registered write port: a `done` pulse, a write enable, the destination index and the quotient. The flags are only read, never written.

Top module: `udiv_exec`

## Requirements
- R1: With `enc_dual`=0, a legal word has bits 27:20 = 0x73, bits 15:12 = 1111 and bits 7:4 = 0001. In that encoding, bits 3:0 name the dividend, bits 11:8 the divisor, bits 19:16 the destination and bits 31:28 the condition.
- R2: With `enc_dual`=1, a legal word has bits 31:20 = 0xFBB, bits 15:12 = 1111 and bits 7:4 = 1111. In that encoding, bits 19:16 name the dividend, bits 3:0 the divisor and bits 11:8 the destination, and the condition always passes.
- R3: An accepted word that breaks its fixed-bit pattern raises `undef` for exactly one cycle, the cycle after acceptance. So does a fixed-width word whose condition is 1111. In either case `done` and `wr_en` stay low and `busy` never rises.
- R4: For a fixed-width word, the condition is tested against `nzcv`, with bit 3 = N, bit 2 = Z, bit 1 = C and bit 0 = V. The codes map as follows: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always. A failing condition gives `done` with `wr_en` low, one cycle after acceptance.
- R5: On a passing condition with a non-zero divisor, `wr_data` is the unsigned dividend divided by the divisor, rounded toward zero.
- R6: A zero divisor with a passing condition gives `done` and `wr_en` with `wr_data` = 0 one cycle after acceptance, and `busy` stays low.
- R7: A non-zero divide holds `busy` high for exactly 32 cycles, starting the cycle after acceptance. `done` is high in the first cycle after `busy` falls.
- R8: `start` is accepted only while `busy` is low. A start seen while busy has no effect on the running divide or on the outputs.
- R9: `done` and `wr_en` are single-cycle pulses. `wr_en` is high only with `done`, and `wr_idx` then carries the decoded destination. After reset all pulses and `busy` are low.
- R10: `src_num_idx` and `src_den_idx` follow the presented word combinationally. `src_num_val` and `src_den_val` are sampled at the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to execute the presented word |
| instr | input | 32 | Instruction word |
| enc_dual | input | 1 | 1 = dual-halfword encoding, 0 = fixed-width encoding |
| nzcv | input | 4 | Current flags N,Z,C,V (bit 3 to bit 0) |
| src_num_idx | output | 4 | Register index of the dividend |
| src_den_idx | output | 4 | Register index of the divisor |
| src_num_val | input | XLEN | Dividend value read back |
| src_den_val | input | XLEN | Divisor value read back |
| busy | output | 1 | Division loop running |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | One-cycle undefined-instruction pulse |
| wr_en | output | 1 | Write destination register |
| wr_idx | output | 4 | Destination register index |
| wr_data | output | XLEN | Quotient |

## Verification
The hardest situation to reach is a start that arrives while the loop is running. This matters most when that start would take a fast path, such as a zero divisor or an undefined word, that could finish inside the running divide's window. The stimulus issues a long divide and then holds `start` high with a conflicting fast-path word for several mid-loop cycles. It then checks that only the original quotient appears, exactly 32 cycles later. The full condition table is swept with zero-divisor words, so each code resolves within one cycle, under four flag patterns. Back-to-back fast-path starts are also issued, so that a new acceptance lands in the same cycle as the previous `done`.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
  localparam int RIDX_W = 4;
  localparam logic [7:0]  FIX_OPC   = 8'h73;
  localparam logic [11:0] DUAL_OPC  = 12'hFBB;
  localparam logic [3:0]  COND_AL   = 4'hE;
  localparam logic [3:0]  COND_RSVD = 4'hF;

  typedef struct packed {
    logic              legal;
    logic [3:0]        cond;
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] num;
    logic [RIDX_W-1:0] den;
  } dec_t;
endpackage

// File: rtl/udiv_decode.sv
module udiv_decode
  import udiv_pkg::*;
(
  input  logic [31:0] word,
  input  logic        dual,
  output dec_t        dec
);
  logic fix_ok, dual_ok;

  always_comb begin
    fix_ok  = (word[27:20] == FIX_OPC) && (word[15:12] == 4'hF) &&
              (word[7:4] == 4'h1) && (word[31:28] != COND_RSVD);
    dual_ok = (word[31:20] == DUAL_OPC) && (word[15:12] == 4'hF) &&
              (word[7:4] == 4'hF);
    dec = '0;
    if (dual) begin
      dec.legal = dual_ok;
      dec.cond  = COND_AL;
      dec.dst   = word[11:8];
      dec.num   = word[19:16];
      dec.den   = word[3:0];
    end else begin
      dec.legal = fix_ok;
      dec.cond  = word[31:28];
      dec.dst   = word[19:16];
      dec.num   = word[3:0];
      dec.den   = word[11:8];
    end
  end
endmodule

// File: rtl/udiv_cond.sv
module udiv_cond (
  input  logic [3:0] cond,
  input  logic [3:0] nzcv,
  output logic       pass
);
  logic n, z, c, v;
  assign n = nzcv[3];
  assign z = nzcv[2];
  assign c = nzcv[1];
  assign v = nzcv[0];

  always_comb begin
    case (cond)
      4'd0:    pass = z;
      4'd1:    pass = !z;
      4'd2:    pass = c;
      4'd3:    pass = !c;
      4'd4:    pass = n;
      4'd5:    pass = !n;
      4'd6:    pass = v;
      4'd7:    pass = !v;
      4'd8:    pass = c && !z;
      4'd9:    pass = !c || z;
      4'd10:   pass = (n == v);
      4'd11:   pass = (n != v);
      4'd12:   pass = !z && (n == v);
      4'd13:   pass = z || (n != v);
      4'd14:   pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/udiv_core.sv
module udiv_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         last,
  output logic [W-1:0] q_next
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [W:0]    shifted, trial;
  logic          fits;
  logic [W-1:0]  rem_next;

  always_comb begin
    shifted  = {rem_q, quo_q[W-1]};
    trial    = shifted - {1'b0, den_q};
    fits     = !trial[W];
    rem_next = fits ? trial[W-1:0] : shifted[W-1:0];
    q_next   = {quo_q[W-2:0], fits};
  end

  assign busy = busy_q;
  assign last = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(W - 1);
      rem_q  <= '0;
      quo_q  <= num;
      den_q  <= den;
    end else if (busy_q) begin
      rem_q <= rem_next;
      quo_q <= q_next;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == '0) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/udiv_exec.sv
module udiv_exec
  import udiv_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       instr,
  input  logic              enc_dual,
  input  logic [3:0]        nzcv,
  output logic [RIDX_W-1:0] src_num_idx,
  output logic [RIDX_W-1:0] src_den_idx,
  input  logic [XLEN-1:0]   src_num_val,
  input  logic [XLEN-1:0]   src_den_val,
  output logic              busy,
  output logic              done,
  output logic              undef,
  output logic              wr_en,
  output logic [RIDX_W-1:0] wr_idx,
  output logic [XLEN-1:0]   wr_data
);
  dec_t              dec;
  logic              cond_ok;
  logic              accept, den_zero, load;
  logic              core_busy, core_last;
  logic [XLEN-1:0]   core_q;
  logic              done_q, we_q, undef_q;
  logic [RIDX_W-1:0] idx_q, pend_idx;
  logic [XLEN-1:0]   data_q;

  udiv_decode u_dec (.word(instr), .dual(enc_dual), .dec(dec));
  udiv_cond   u_cond (.cond(dec.cond), .nzcv(nzcv), .pass(cond_ok));

  assign src_num_idx = dec.num;
  assign src_den_idx = dec.den;
  assign accept      = start && !core_busy;
  assign den_zero    = (src_den_val == '0);
  assign load        = accept && dec.legal && cond_ok && !den_zero;

  udiv_core #(.W(XLEN)) u_core (
    .clk(clk), .rst(rst), .load(load),
    .num(src_num_val), .den(src_den_val),
    .busy(core_busy), .last(core_last), .q_next(core_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q   <= 1'b0;
      we_q     <= 1'b0;
      undef_q  <= 1'b0;
      idx_q    <= '0;
      data_q   <= '0;
      pend_idx <= '0;
    end else begin
      done_q  <= 1'b0;
      we_q    <= 1'b0;
      undef_q <= 1'b0;
      if (core_last) begin
        done_q <= 1'b1;
        we_q   <= 1'b1;
        idx_q  <= pend_idx;
        data_q <= core_q;
      end else if (accept) begin
        if (!dec.legal) begin
          undef_q <= 1'b1;
        end else if (!cond_ok) begin
          done_q <= 1'b1;
        end else if (den_zero) begin
          done_q <= 1'b1;
          we_q   <= 1'b1;
          idx_q  <= dec.dst;
          data_q <= '0;
        end else begin
          pend_idx <= dec.dst;
        end
      end
    end
  end

  assign busy    = core_busy;
  assign done    = done_q;
  assign wr_en   = we_q;
  assign undef   = undef_q;
  assign wr_idx  = idx_q;
  assign wr_data = data_q;
endmodule

// File: rtl/udiv_exec_chk.sv
module udiv_exec_chk #(
  parameter int XLEN = 32
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic undef,
  input logic wr_en
);
  localparam int BW = $clog2(XLEN + 1) + 1;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) bcnt <= '0;
    else              bcnt <= bcnt + 1'b1;
  end

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && (bcnt == BW'(XLEN))));

  // R7
  busy_cont_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && (bcnt < BW'(XLEN - 1))) |=> busy);

  // R9
  we_done_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> done);

  // R3
  undef_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    undef |-> (!done && !busy && !wr_en));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !undef);
endmodule

bind udiv_exec udiv_exec_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .done(done), .undef(undef), .wr_en(wr_en)
);

// File: tb/udiv_exec_bench.sv
`timescale 1ns/1ps
module udiv_exec_bench;
  logic        clk = 1'b0;
  logic        rst, start, dual;
  logic [31:0] instr;
  logic [3:0]  nzcv;
  logic [3:0]  s_num, s_den, wr_idx;
  logic [31:0] v_num, v_den, wr_data;
  logic        busy, done, undef, wr_en;
  logic [31:0] regs [16];

  int    n_chk = 0, n_err = 0;
  bit    fin = 0;
  string scen = "reset";

  always #2.5 clk = ~clk;

  assign v_num = regs[s_num];
  assign v_den = regs[s_den];

  udiv_exec u_udiv_exec (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .enc_dual(dual),
    .nzcv(nzcv), .src_num_idx(s_num), .src_den_idx(s_den),
    .src_num_val(v_num), .src_den_val(v_den), .busy(busy), .done(done),
    .undef(undef), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s [%s] got=%h exp=%h t=%0t", tag, scen, got, exp, $time);
    end
  endtask

  function automatic bit cond_eval(input logic [3:0] c, input logic [3:0] f);
    bit nf = f[3], zf = f[2], cf = f[1], vf = f[0], base;
    case (c[3:1])
      3'd0: base = zf;
      3'd1: base = cf;
      3'd2: base = nf;
      3'd3: base = vf;
      3'd4: base = cf & ~zf;
      3'd5: base = (nf == vf);
      3'd6: base = ~zf & (nf == vf);
      default: return 1'b1;
    endcase
    return c[0] ? ~base : base;
  endfunction

  function automatic void ref_dec(input logic [31:0] w, input bit dl, input logic [3:0] f,
                                  output bit ok, output bit go, output int d, output int n, output int m);
    if (dl) begin
      ok = ((w & 32'hFFF0_F0F0) == 32'hFBB0_F0F0);
      d = int'(w[11:8]); n = int'(w[19:16]); m = int'(w[3:0]); go = 1;
    end else begin
      ok = ((w & 32'h0FF0_F0F0) == 32'h0730_F010) && (w[31:28] != 4'hF);
      d = int'(w[19:16]); n = int'(w[3:0]); m = int'(w[11:8]);
      go = cond_eval(w[31:28], f);
    end
  endfunction

  // behavioural reference, advanced on every clock
  bit m_busy, m_done, m_undef, m_we;
  int m_cnt;
  logic [3:0]  m_idx, p_idx;
  logic [31:0] m_data, p_q;

  always @(posedge clk) begin
    bit ok, go; int d, n, m;
    if (rst) begin
      m_busy <= 0; m_done <= 0; m_undef <= 0; m_we <= 0; m_cnt <= 0;
    end else begin
      m_done <= 0; m_undef <= 0; m_we <= 0;
      if (m_busy) begin
        if (m_cnt == 1) begin
          m_busy <= 0; m_done <= 1; m_we <= 1; m_idx <= p_idx; m_data <= p_q;
        end
        m_cnt <= m_cnt - 1;
      end else if (start) begin
        ref_dec(instr, dual, nzcv, ok, go, d, n, m);
        if (!ok) m_undef <= 1;
        else if (!go) m_done <= 1;
        else if (regs[m] == 0) begin
          m_done <= 1; m_we <= 1; m_idx <= 4'(d); m_data <= 0;
        end else begin
          m_busy <= 1; m_cnt <= 32; p_idx <= 4'(d); p_q <= regs[n] / regs[m];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !fin) begin
      chk("R7 busy", {31'b0, busy}, {31'b0, m_busy});
      chk("R9 done", {31'b0, done}, {31'b0, m_done});
      chk("R3 undef", {31'b0, undef}, {31'b0, m_undef});
      chk("R9 wr_en", {31'b0, wr_en}, {31'b0, m_we});
      if (m_we) begin
        chk("R9 wr_idx", {28'b0, wr_idx}, {28'b0, m_idx});
        chk("R5 wr_data", wr_data, m_data);
      end
    end
  end

  function automatic logic [31:0] wfix(input logic [3:0] c, input logic [3:0] d,
                                       input logic [3:0] n, input logic [3:0] m);
    return {c, 8'h73, d, 4'hF, m, 4'h1, n};
  endfunction

  function automatic logic [31:0] wdual(input logic [3:0] d, input logic [3:0] n, input logic [3:0] m);
    return {12'hFBB, n, 4'hF, d, 4'hF, m};
  endfunction

  task automatic issue(input logic [31:0] w, input bit dl, input logic [3:0] f);
    bit ok, go; int d, n, m;
    instr = w; dual = dl; nzcv = f; start = 1;
    #1;
    ref_dec(w, dl, f, ok, go, d, n, m);
    if (ok) begin
      chk("R10 num idx", {28'b0, s_num}, 32'(n));
      chk("R10 den idx", {28'b0, s_den}, 32'(m));
    end
    @(negedge clk);
    start = 0;
  endtask

  task automatic settle();
    int k = 0;
    while ((m_busy || busy) && k < 60) begin @(negedge clk); k++; end
    @(negedge clk); @(negedge clk);
  endtask

  task automatic run(input logic [31:0] w, input bit dl, input logic [3:0] f);
    issue(w, dl, f);
    settle();
  endtask

  task automatic divide_fix(input logic [31:0] a, input logic [31:0] b);
    regs[3] = a; regs[4] = b;
    run(wfix(4'hE, 4'd7, 4'd3, 4'd4), 0, 4'h0);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired [%s]", scen);
    fin = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst = 1; start = 0; instr = 0; dual = 0; nzcv = 0;
    for (int i = 0; i < 16; i++) regs[i] = 32'(i * 1000 + 17);
    repeat (3) @(negedge clk);
    chk("R9 reset busy", {31'b0, busy}, 0);
    chk("R9 reset done", {31'b0, done}, 0);
    chk("R9 reset undef", {31'b0, undef}, 0);
    chk("R9 reset wr_en", {31'b0, wr_en}, 0);
    rst = 0;
    @(negedge clk);

    scen = "R1 fixed-width divide";
    regs[1] = 100; regs[2] = 7;
    run(wfix(4'hE, 4'd9, 4'd1, 4'd2), 0, 4'h0);

    scen = "R2 dual-halfword divide";
    regs[5] = 32'd1_000_000; regs[6] = 32'd333;
    run(wdual(4'd11, 4'd5, 4'd6), 1, 4'h4);

    scen = "R5 dividend below divisor";      divide_fix(5, 9);
    scen = "R5 all-ones by one";             divide_fix(32'hFFFF_FFFF, 1);
    scen = "R5 equal operands";              divide_fix(32'h1234_5678, 32'h1234_5678);
    scen = "R5 all-ones by all-ones";        divide_fix(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    scen = "R5 top bit by three";            divide_fix(32'h8000_0000, 3);
    scen = "R6 zero divisor";                divide_fix(32'hDEAD_BEEF, 0);

    scen = "R6 back-to-back zero divisor";
    regs[8] = 0;
    issue(wfix(4'hE, 4'd1, 4'd2, 4'd8), 0, 4'h0);
    issue(wdual(4'd12, 4'd3, 4'd8), 1, 4'h0);
    settle();

    scen = "R4 condition sweep";
    regs[8] = 0;
    for (int c = 0; c < 15; c++) begin
      for (int p = 0; p < 4; p++) begin
        logic [3:0] fl;
        fl = (p == 0) ? 4'h0 : (p == 1) ? 4'hF : (p == 2) ? 4'h6 : 4'h9;
        run(wfix(4'(c), 4'd10, 4'd2, 4'd8), 0, fl);
      end
    end
    regs[1] = 77; regs[2] = 5;
    run(wfix(4'h0, 4'd9, 4'd1, 4'd2), 0, 4'h0);
    run(wfix(4'h0, 4'd9, 4'd1, 4'd2), 0, 4'h4);

    scen = "R3 bad fixed bits";
    run(wfix(4'hE, 4'd1, 4'd2, 4'd3) ^ 32'h0000_8000, 0, 4'h0);
    run(wfix(4'hE, 4'd1, 4'd2, 4'd3) ^ 32'h0000_0010, 0, 4'h0);
    run(wfix(4'hE, 4'd1, 4'd2, 4'd3) ^ 32'h0010_0000, 0, 4'h0);
    run(wfix(4'hF, 4'd1, 4'd2, 4'd3), 0, 4'h0);
    scen = "R3 bad dual bits";
    run(wdual(4'd1, 4'd2, 4'd3) ^ 32'h0000_0080, 1, 4'h0);
    run(wdual(4'd1, 4'd2, 4'd3) ^ 32'h8000_0000, 1, 4'h0);
    scen = "R3 fixed word flagged as dual";
    run(wfix(4'hE, 4'd1, 4'd2, 4'd3), 1, 4'h0);

    scen = "R8 start while busy";
    regs[1] = 32'hCAFE_F00D; regs[2] = 32'd13; regs[8] = 0;
    issue(wfix(4'hE, 4'd4, 4'd1, 4'd2), 0, 4'h0);
    repeat (4) @(negedge clk);
    instr = wfix(4'hE, 4'd6, 4'd1, 4'd8); dual = 0; start = 1;
    repeat (3) @(negedge clk);
    instr = 32'h0; start = 1;
    repeat (3) @(negedge clk);
    start = 0;
    settle();

    scen = "R5 random operands";
    for (int r = 0; r < 30; r++) begin
      regs[3] = $urandom;
      regs[4] = $urandom >> ($urandom % 32);
      run(wfix(4'hE, 4'(r), 4'd3, 4'd4), 0, 4'h0);
    end

    fin = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule